// File: doc/BRIEF.md
# Banked Shared Memory Conflict Arbiter

This block is the front end of a 16 KB on-chip scratch memory shared by a group of sixteen threads. In one request, each thread may present one 32-bit access: a valid bit, a write enable, a word address and write data. The memory is built from sixteen independent banks, each one word wide. A word goes to the bank named by the low bits of its word address, so consecutive words fall in consecutive banks.

When two or more valid threads in a request name the same bank, those accesses collide. The block resolves a collision by running the request as a series of passes. In each pass, every bank serves the lowest-numbered thread that still waits on it. Each pass occupies a bank for two clock cycles. When every pass has finished, the block pulses `done` and presents each thread's read data together with the number of passes used.

Requests enter on a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge that accepts a request until the cycle in which `done` is high. A `req_valid` held high while busy simply waits and takes no effect. The result side has no back-pressure: `rsp_rdata` and `passes` hold their values from the `done` cycle until the next request is accepted.

Top module: `smem_bank_arbiter`

## Requirements
- R1: The bank of an access is word-address bits [3:0] (byte-address bits [5:2]), and the row inside the bank is word-address bits [11:4]. Two accesses conflict exactly when their bank fields are equal.
- R2: A valid read returns the word most recently written to its address, and a valid write stores its data at its address.
- R3: `passes` in the `done` cycle equals the largest number of valid threads that map to any single bank. Requests to the same address are counted separately.
- R4: Threads that share a bank are served in ascending thread index, one per pass. A read therefore sees a write to the same address from a lower-numbered thread of the same request, and it does not see one from a higher-numbered thread.
- R5: With P passes, `done` is high in the cycle that follows the (2P+1)-th rising edge after the accepting edge, so each pass takes two cycles and one more cycle follows the last pass.
- R6: `req_ready` is high when idle and low from the accepting edge until the `done` cycle. A request presented while busy has no effect on the memory.
- R7: `done` is a single-cycle pulse. `rsp_rdata` and `passes` stay stable after it until the next request is accepted.
- R8: An invalid thread makes no access, and its read-data slot returns zero. A request with no valid thread completes with zero passes and `done` one cycle after acceptance.
- R9: The read-data slot of a thread that writes returns zero.
- R10: During and after reset, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | 16 | Per-thread valid bit |
| req_we | input | 16 | Per-thread write enable |
| req_addr | input | 192 | Per-thread 12-bit word address, thread t at bits [12t+11:12t] |
| req_wdata | input | 512 | Per-thread write word, thread t at bits [32t+31:32t] |
| done | output | 1 | One-cycle completion pulse |
| passes | output | 5 | Number of passes used by the finished request |
| rsp_rdata | output | 512 | Per-thread read word, same packing as `req_wdata` |

## Verification
The only timed result is the `done` pulse, which is due 2P+1 edges after the accepting edge, where the bench derives P from its own per-bank count of the request. The bench counts falling edges from acceptance until `done` appears, compares that count with 2P+1, and samples `passes` and every read slot in that same cycle. It then checks one falling edge later that `done` has dropped and that the results are unchanged. All inputs change on falling edges, so every sample lies half a cycle away from the edge that produced it.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int SMEM_THREADS = 16;
  localparam int SMEM_BANKS   = 16;
  localparam int SMEM_DATA_W  = 32;
  localparam int SMEM_ROWS    = 256;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_COLLECT = 2'd2
  } sched_st_e;
endpackage

// File: rtl/smem_conflict_pick.sv
module smem_conflict_pick #(
  parameter int N_THR  = 16,
  parameter int N_BANK = 16,
  parameter int BIDX_W = 4,
  parameter int TIDX_W = 4
) (
  input  logic [N_THR-1:0]         pending,
  input  logic [N_THR*BIDX_W-1:0]  bank_of,
  output logic [N_THR-1:0]         grant,
  output logic [N_BANK-1:0]        bank_en,
  output logic [N_BANK*TIDX_W-1:0] bank_thr
);
  always_comb begin
    for (int t = 0; t < N_THR; t++) begin
      grant[t] = pending[t];
      for (int j = 0; j < N_THR; j++) begin
        if (j < t && pending[j] &&
            bank_of[j*BIDX_W +: BIDX_W] == bank_of[t*BIDX_W +: BIDX_W])
          grant[t] = 1'b0;
      end
    end
  end

  always_comb begin
    bank_en  = '0;
    bank_thr = '0;
    for (int b = 0; b < N_BANK; b++) begin
      for (int t = N_THR - 1; t >= 0; t--) begin
        if (grant[t] && bank_of[t*BIDX_W +: BIDX_W] == BIDX_W'(b)) begin
          bank_en[b]                  = 1'b1;
          bank_thr[b*TIDX_W +: TIDX_W] = TIDX_W'(t);
        end
      end
    end
  end
endmodule

// File: rtl/smem_bank.sv
module smem_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 256,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) cells[row] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (en && !we) rdata <= cells[row];
  end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
  import smem_pkg::*;
#(
  parameter int N_THR     = SMEM_THREADS,
  parameter int N_BANK    = SMEM_BANKS,
  parameter int DATA_W    = SMEM_DATA_W,
  parameter int BANK_ROWS = SMEM_ROWS,
  localparam int BIDX_W  = $clog2(N_BANK),
  localparam int ROW_W   = $clog2(BANK_ROWS),
  localparam int WADDR_W = BIDX_W + ROW_W,
  localparam int TIDX_W  = $clog2(N_THR),
  localparam int CNT_W   = $clog2(N_THR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [N_THR-1:0]          req_mask,
  input  logic [N_THR-1:0]          req_we,
  input  logic [N_THR*WADDR_W-1:0]  req_addr,
  input  logic [N_THR*DATA_W-1:0]   req_wdata,
  output logic                      done,
  output logic [CNT_W-1:0]          passes,
  output logic [N_THR*DATA_W-1:0]   rsp_rdata
);
  sched_st_e           st_q;
  logic [N_THR-1:0]    pend_q, grant_q, we_q;
  logic [WADDR_W-1:0]  addr_q  [N_THR];
  logic [DATA_W-1:0]   wdata_q [N_THR];
  logic [DATA_W-1:0]   rdata_q [N_THR];
  logic [CNT_W-1:0]    pass_q;
  logic                done_q;

  logic [N_THR*BIDX_W-1:0]  bank_of;
  logic [N_THR-1:0]         grant_c;
  logic [N_BANK-1:0]        bank_en_c;
  logic [N_BANK*TIDX_W-1:0] bank_thr_c;
  logic [DATA_W-1:0]        bank_rd [N_BANK];

  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign passes    = pass_q;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign bank_of[t*BIDX_W +: BIDX_W]   = addr_q[t][BIDX_W-1:0];
    assign rsp_rdata[t*DATA_W +: DATA_W] = rdata_q[t];
  end

  smem_conflict_pick #(
    .N_THR(N_THR), .N_BANK(N_BANK), .BIDX_W(BIDX_W), .TIDX_W(TIDX_W)
  ) u_pick (
    .pending (pend_q),
    .bank_of (bank_of),
    .grant   (grant_c),
    .bank_en (bank_en_c),
    .bank_thr(bank_thr_c)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [TIDX_W-1:0] sel;
    assign sel = bank_thr_c[b*TIDX_W +: TIDX_W];
    smem_bank #(.DATA_W(DATA_W), .ROWS(BANK_ROWS)) u_bank (
      .clk  (clk),
      .en   (bank_en_c[b] && (st_q == ST_ISSUE)),
      .we   (we_q[sel]),
      .row  (addr_q[sel][WADDR_W-1:BIDX_W]),
      .wdata(wdata_q[sel]),
      .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      grant_q <= '0;
      we_q    <= '0;
      pass_q  <= '0;
      done_q  <= 1'b0;
      for (int t = 0; t < N_THR; t++) begin
        addr_q[t]  <= '0;
        wdata_q[t] <= '0;
        rdata_q[t] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            pend_q <= req_mask;
            we_q   <= req_we;
            pass_q <= '0;
            for (int t = 0; t < N_THR; t++) begin
              addr_q[t]  <= req_addr[t*WADDR_W +: WADDR_W];
              wdata_q[t] <= req_wdata[t*DATA_W +: DATA_W];
              rdata_q[t] <= '0;
            end
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (pend_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            grant_q <= grant_c;
            st_q    <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          for (int t = 0; t < N_THR; t++) begin
            if (grant_q[t] && !we_q[t])
              rdata_q[t] <= bank_rd[addr_q[t][BIDX_W-1:0]];
          end
          pend_q <= pend_q & ~grant_q;
          pass_q <= pass_q + CNT_W'(1);
          st_q   <= ST_ISSUE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_chk.sv
module smem_chk #(
  parameter int N_THR = 16,
  parameter int CNT_W = 5,
  localparam int CYC_W = CNT_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [CNT_W-1:0] passes
);
  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (req_valid && req_ready) cyc <= '0;
    else if (cyc != '1) cyc <= cyc + CYC_W'(1);
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == (CYC_W'(passes) << 1) + CYC_W'(1))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R6
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R6
  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (passes <= CNT_W'(N_THR))); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && !done) |=> $stable(passes)); // R7
endmodule

bind smem_bank_arbiter smem_chk #(.N_THR(N_THR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .passes(passes)
);

// File: tb/tb_smem_bank_arbiter.sv
module tb_smem_bank_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int WA = 12;
  localparam int CW = 5;

  logic clk, rst_n, req_valid, req_ready, done;
  logic [NT-1:0] req_mask, req_we;
  logic [NT*WA-1:0] req_addr;
  logic [NT*DW-1:0] req_wdata, rsp_rdata;
  logic [CW-1:0] passes;

  smem_bank_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .passes(passes), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  bit [31:0] model [4096];
  bit        m_val [NT];
  bit        m_we  [NT];
  bit [11:0] m_wa  [NT];
  bit [31:0] m_wd  [NT];
  bit [31:0] exp_rd [NT];
  int        exp_p;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void predict();
    int cnt [NB];
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    exp_p = 0;
    for (int t = 0; t < NT; t++) begin
      exp_rd[t] = 32'h0;
      if (m_val[t]) begin
        cnt[m_wa[t][3:0]]++;
        if (m_we[t]) model[m_wa[t]] = m_wd[t];
        else exp_rd[t] = model[m_wa[t]];
      end
    end
    for (int b = 0; b < NB; b++) if (cnt[b] > exp_p) exp_p = cnt[b];
  endfunction

  task automatic run_req(input bit junk, input string ptag);
    int k;
    bit rdy_bad;
    logic [NT*DW-1:0] held;
    predict();
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      req_mask[t] = m_val[t];
      req_we[t]   = m_we[t];
      req_addr[t*WA +: WA]  = m_wa[t];
      req_wdata[t*DW +: DW] = m_wd[t];
    end
    req_valid = 1'b1;
    check(req_ready === 1'b1, "R6", "idle ready", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    rdy_bad = 0;
    while (done !== 1'b1 && k < 200) begin
      if (req_ready !== 1'b0) rdy_bad = 1;
      if (junk) begin
        for (int t = 0; t < NT; t++) begin
          req_mask[t] = 1'b1;
          req_we[t]   = 1'b1;
          req_addr[t*WA +: WA]  = WA'(t);
          req_wdata[t*DW +: DW] = 32'hDEAD_BEEF;
        end
        req_valid = 1'b1;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    check(!rdy_bad, "R6", "ready low while busy", rdy_bad, 0);
    check(k == 2*exp_p + 1, "R5", "done latency", k, 2*exp_p + 1);
    check(passes == CW'(exp_p), ptag, "pass count", passes, exp_p);
    check(req_ready === 1'b1, "R6", "ready in done cycle", req_ready, 1);
    for (int t = 0; t < NT; t++) begin
      string tg;
      tg = !m_val[t] ? "R8" : (m_we[t] ? "R9" : "R2");
      check(rsp_rdata[t*DW +: DW] == exp_rd[t], tg, $sformatf("rdata thread %0d", t),
            rsp_rdata[t*DW +: DW], exp_rd[t]);
    end
    held = rsp_rdata;
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
    check(rsp_rdata == held && passes == CW'(exp_p), "R7", "results held",
          rsp_rdata[31:0], held[31:0]);
  endtask

  function automatic void clear_req();
    for (int t = 0; t < NT; t++) begin
      m_val[t] = 0; m_we[t] = 0; m_wa[t] = '0; m_wd[t] = '0;
    end
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_mask = '0; req_we = '0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && done === 1'b0, "R10", "in reset", {req_ready, done}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && done === 1'b0, "R10", "after reset", {req_ready, done}, 2'b10);

    // fill every word, one thread per bank: one pass each (R1, R2)
    for (int i = 0; i < 256; i++) begin
      for (int t = 0; t < NT; t++) begin
        m_val[t] = 1; m_we[t] = 1;
        m_wa[t] = {i[7:0], t[3:0]};
        m_wd[t] = $urandom;
      end
      run_req(0, "R1");
    end

    // R1: differing only in row bits -> all in bank 0, 16 passes
    for (int t = 0; t < NT; t++) begin
      m_val[t] = 1; m_we[t] = 0; m_wa[t] = {t[7:0], 4'd0};
    end
    run_req(0, "R1");

    // R1/R3: stride of two words -> even banks, 2-way conflict
    for (int t = 0; t < NT; t++) begin
      m_val[t] = 1; m_we[t] = 0; m_wa[t] = 12'(t * 2 + 64);
    end
    run_req(0, "R3");

    // R4: ordering within one bank, same address
    clear_req();
    m_val[0] = 1; m_we[0] = 1; m_wa[0] = 12'h105; m_wd[0] = 32'h1111_0000;
    m_val[1] = 1; m_we[1] = 0; m_wa[1] = 12'h105;
    m_val[2] = 1; m_we[2] = 1; m_wa[2] = 12'h105; m_wd[2] = 32'h2222_0000;
    m_val[3] = 1; m_we[3] = 0; m_wa[3] = 12'h105;
    run_req(0, "R4");
    check(exp_rd[1] == 32'h1111_0000 && exp_rd[3] == 32'h2222_0000, "R4",
          "order model", exp_rd[1], 32'h1111_0000);

    // R4: lower-numbered read does not see higher-numbered write
    clear_req();
    m_val[4] = 1; m_we[4] = 0; m_wa[4] = 12'h205;
    m_val[9] = 1; m_we[9] = 1; m_wa[9] = 12'h205; m_wd[9] = 32'hABCD_1234;
    run_req(0, "R4");

    // R8: empty request
    clear_req();
    run_req(0, "R8");

    // R6: request driven while busy must be ignored
    for (int t = 0; t < NT; t++) begin
      m_val[t] = 1; m_we[t] = 0; m_wa[t] = {t[7:0], 4'd3};
    end
    run_req(1, "R3");
    for (int t = 0; t < NT; t++) begin
      m_val[t] = 1; m_we[t] = 0; m_wa[t] = 12'(t);
    end
    run_req(0, "R6");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int mode;
      mode = $urandom_range(0, 2);
      for (int t = 0; t < NT; t++) begin
        m_val[t] = ($urandom_range(0, 3) != 0);
        m_we[t]  = $urandom_range(0, 1);
        m_wd[t]  = $urandom;
        case (mode)
          0: m_wa[t] = 12'($urandom);
          1: m_wa[t] = {6'd0, 2'($urandom), 4'($urandom_range(0, 2))};
          default: m_wa[t] = {8'($urandom_range(0, 3)), 4'($urandom)};
        endcase
      end
      run_req(0, "R3");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule